// File: doc/BRIEF.md
# DDR Write-Leveling Calibration Sequencer

This block drives one complete write-leveling pass on a DDR memory controller through a simple register-bus master port. A single-cycle start pulse launches a fixed, ordered series of bus reads and writes. The series quiets the controller's power-down timers, saves and disables auto-refresh and periodic ZQ calibration, and issues a mode-register command that places the memory in write-leveling mode. It then starts the controller's hardware leveling engine and polls the engine's go bit until it clears.

After the engine finishes, the sequencer reads the leveling status of both PHY instances and raises an error flag if either one reports a failure. It then issues the mode-register command that leaves leveling mode, writes back the saved refresh and ZQ settings, re-arms the power-down timers and clears the command register. A poll loop that never completes is cut off after a parameterised number of busy reads. In that case a timeout flag is raised, the status checks are skipped, and the exit and restore writes still run. Each bus access holds its address, data and strobe until the slave answers with ready.

Top module: `wl_calib_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, err_o, timeout_o, bus_we_o and bus_re_o are all 0.
- R2: At most one of bus_we_o and bus_re_o is high at a time. Once a strobe is raised, the strobe, bus_addr_o and bus_wdata_o hold unchanged until a cycle with bus_ready_i high completes the access. Read data is taken from bus_rdata_i in that cycle.
- R3: The run begins with two read-modify-writes. The power-down control register (offset 0x004) is written back with bits [15:8] cleared. The power-saving register (offset 0x404) is written back with bit 0 set.
- R4: The refresh register (0x020) is read and then written with 0x0000C000. The ZQ control register (0x800) is read and then written with its read value with bits [1:0] cleared.
- R5: Leveling mode is entered by writing 0x00808231 to the command register (0x01C). The engine is then started by writing 0x00000001 to the leveling control register (0x808).
- R6: The leveling control register is read repeatedly while its bit 0 reads 1. The first read showing bit 0 = 0 ends the poll.
- R7: After the poll, the leveling control register of PHY 0 (0x808) is read, then that of PHY 1 (PHY1_BASE + 0x808). err_o is set when bits [11:8] of either value are nonzero. Other bits have no effect on err_o.
- R8: When POLL_MAX consecutive poll reads all return bit 0 = 1, timeout_o is set. Both PHY status reads are then skipped, and the run continues at the leveling exit command.
- R9: The run closes with these writes in this order: 0x00048031 to the command register; the saved refresh value; the saved ZQ value; power-down control read back and written with bits 0x5500 set; power-saving read back and written with bit 3 cleared; and 0x00000000 to the command register.
- R10: done_o is high for exactly one cycle, right after the final command-register write completes; busy_o is low from that cycle on. err_o and timeout_o keep their values until the next start, which clears them.
- R11: A start_i pulse while busy_o is high has no effect. The access stream and flags are those of the run already in progress, and no second run follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, honoured only while idle |
| bus_addr_o | output | AW | Register-bus address |
| bus_wdata_o | output | DW | Register-bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | DW | Register-bus read data, valid with ready |
| bus_ready_i | input | 1 | Slave completes the current access |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | A PHY reported a leveling failure |
| timeout_o | output | 1 | Engine poll exceeded POLL_MAX busy reads |

## Verification
Seven runs go against a register-slave model with varying ready latency, each compared access by access with an expected stream.

- **Busy-read counts:** the engine clears after 0, 1, 2, 3 and 7 busy reads. Against 8 and 20 with POLL_MAX = 8, this separates a correct poll from an off-by-one in the timeout limit.
- **Status values:** failure bits are placed on PHY 0 only, on PHY 1 only, and only outside bits [11:8]. This shows that both PHYs are checked and that the field is masked.
- **Skipped checks on timeout:** in one timeout run the status carries failure bits. A design that still read the PHY status would be exposed.
- **Start while busy:** repeated start pulses during a run, and quiet bus cycles after done, show that a mid-run start is dropped.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned REG_AW = 16;

  localparam logic [REG_AW-1:0] OFS_PDC = 16'h0004;
  localparam logic [REG_AW-1:0] OFS_APS = 16'h0404;
  localparam logic [REG_AW-1:0] OFS_REF = 16'h0020;
  localparam logic [REG_AW-1:0] OFS_ZQ  = 16'h0800;
  localparam logic [REG_AW-1:0] OFS_CMD = 16'h001C;
  localparam logic [REG_AW-1:0] OFS_LVL = 16'h0808;

  localparam logic [31:0] REF_OFF_VAL   = 32'h0000_C000;
  localparam logic [31:0] PDC_TMR_MASK  = 32'h0000_FF00;
  localparam logic [31:0] PDC_TMR_SET   = 32'h0000_5500;
  localparam logic [15:0] CMD_LO_ENTER  = 16'h8231;
  localparam logic [15:0] CMD_LO_EXIT   = 16'h8031;
  localparam int unsigned ERR_LSB = 8;
  localparam int unsigned ERR_W   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} seq_state_e;

  typedef enum logic [4:0] {
    S_PDC_RD, S_PDC_WR, S_APS_RD, S_APS_WR,
    S_REF_RD, S_REF_WR, S_ZQ_RD, S_ZQ_WR,
    S_WL_ENTER, S_ENG_GO, S_ENG_POLL, S_CHK0, S_CHK1,
    S_WL_EXIT, S_REF_RST, S_ZQ_RST,
    S_PDC_RD2, S_PDC_WR2, S_APS_RD2, S_APS_WR2, S_CMD_CLR
  } step_e;
endpackage

// File: rtl/wl_bus_port.sv
module wl_bus_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          go_we_i,
  input  logic [AW-1:0] go_addr_i,
  input  logic [DW-1:0] go_wdata_i,
  input  logic          ready_i,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ack_o
);
  assign ack_o = (we_o | re_o) & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (go_i) begin
      we_o    <= go_we_i;
      re_o    <= ~go_we_i;
      addr_o  <= go_addr_i;
      wdata_o <= go_we_i ? go_wdata_i : '0;
    end else if (ack_o) begin
      we_o <= 1'b0;
      re_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wl_step_dec.sv
module wl_step_dec
  import wl_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter logic [AW-1:0] PHY1_BASE = 16'h4000,
  parameter logic [15:0] MR1_WL    = 16'h0080,
  parameter logic [15:0] MR1_INIT  = 16'h0004
) (
  input  step_e         step_i,
  input  logic [DW-1:0] held_i,
  input  logic [DW-1:0] save_ref_i,
  input  logic [DW-1:0] save_zq_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [DW-1:0] ENTER_CMD = DW'({MR1_WL, CMD_LO_ENTER});
  localparam logic [DW-1:0] EXIT_CMD  = DW'({MR1_INIT, CMD_LO_EXIT});
  localparam logic [DW-1:0] TMR_MASK  = DW'(PDC_TMR_MASK);
  localparam logic [DW-1:0] TMR_SET   = DW'(PDC_TMR_SET);
  localparam logic [DW-1:0] ONE       = DW'(1);
  localparam logic [DW-1:0] BIT3      = DW'(8);
  localparam logic [DW-1:0] ZQ_MASK   = DW'(3);

  always_comb begin
    we_o    = 1'b0;
    addr_o  = AW'(OFS_CMD);
    wdata_o = '0;
    unique case (step_i)
      S_PDC_RD, S_PDC_RD2: addr_o = AW'(OFS_PDC);
      S_APS_RD, S_APS_RD2: addr_o = AW'(OFS_APS);
      S_REF_RD:            addr_o = AW'(OFS_REF);
      S_ZQ_RD:             addr_o = AW'(OFS_ZQ);
      S_ENG_POLL, S_CHK0:  addr_o = AW'(OFS_LVL);
      S_CHK1:              addr_o = PHY1_BASE + AW'(OFS_LVL);
      S_PDC_WR: begin we_o = 1'b1; addr_o = AW'(OFS_PDC); wdata_o = held_i & ~TMR_MASK; end
      S_APS_WR: begin we_o = 1'b1; addr_o = AW'(OFS_APS); wdata_o = held_i | ONE; end
      S_REF_WR: begin we_o = 1'b1; addr_o = AW'(OFS_REF); wdata_o = DW'(REF_OFF_VAL); end
      S_ZQ_WR:  begin we_o = 1'b1; addr_o = AW'(OFS_ZQ);  wdata_o = save_zq_i & ~ZQ_MASK; end
      S_WL_ENTER: begin we_o = 1'b1; wdata_o = ENTER_CMD; end
      S_ENG_GO: begin we_o = 1'b1; addr_o = AW'(OFS_LVL); wdata_o = ONE; end
      S_WL_EXIT: begin we_o = 1'b1; wdata_o = EXIT_CMD; end
      S_REF_RST: begin we_o = 1'b1; addr_o = AW'(OFS_REF); wdata_o = save_ref_i; end
      S_ZQ_RST:  begin we_o = 1'b1; addr_o = AW'(OFS_ZQ);  wdata_o = save_zq_i; end
      S_PDC_WR2: begin we_o = 1'b1; addr_o = AW'(OFS_PDC); wdata_o = held_i | TMR_SET; end
      S_APS_WR2: begin we_o = 1'b1; addr_o = AW'(OFS_APS); wdata_o = held_i & ~BIT3; end
      S_CMD_CLR: begin we_o = 1'b1; wdata_o = '0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/wl_poll_cnt.sv
module wl_poll_cnt #(
  parameter int unsigned POLL_MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_MAX - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (hit_i && !last_o) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/wl_calib_seq.sv
module wl_calib_seq
  import wl_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 32,
  parameter logic [AW-1:0] PHY1_BASE = 16'h4000,
  parameter int unsigned   POLL_MAX  = 1024,
  parameter logic [15:0]   MR1_WL    = 16'h0080,
  parameter logic [15:0]   MR1_INIT  = 16'h0004
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          timeout_o
);
  seq_state_e    state_q;
  step_e         step_q;
  logic [DW-1:0] held_q, save_ref_q, save_zq_q;
  logic          err_q, tmo_q, done_q;

  logic          dec_we;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] dec_wdata;
  logic          ack, poll_busy, poll_last;

  wl_step_dec #(
    .AW(AW), .DW(DW), .PHY1_BASE(PHY1_BASE), .MR1_WL(MR1_WL), .MR1_INIT(MR1_INIT)
  ) u_dec (
    .step_i    (step_q),
    .held_i    (held_q),
    .save_ref_i(save_ref_q),
    .save_zq_i (save_zq_q),
    .we_o      (dec_we),
    .addr_o    (dec_addr),
    .wdata_o   (dec_wdata)
  );

  wl_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (state_q == ST_LOAD),
    .go_we_i   (dec_we),
    .go_addr_i (dec_addr),
    .go_wdata_i(dec_wdata),
    .ready_i   (bus_ready_i),
    .we_o      (bus_we_o),
    .re_o      (bus_re_o),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o),
    .ack_o     (ack)
  );

  assign poll_busy = ack && (state_q == ST_WAIT) && (step_q == S_ENG_POLL) && bus_rdata_i[0];

  wl_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == ST_IDLE),
    .hit_i (poll_busy),
    .last_o(poll_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= S_PDC_RD;
      held_q     <= '0;
      save_ref_q <= '0;
      save_zq_q  <= '0;
      err_q      <= 1'b0;
      tmo_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          step_q  <= S_PDC_RD;
          err_q   <= 1'b0;
          tmo_q   <= 1'b0;
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: if (ack) begin
          state_q <= ST_LOAD;
          step_q  <= step_e'(step_q + 5'd1);
          unique case (step_q)
            S_PDC_RD, S_APS_RD, S_PDC_RD2, S_APS_RD2: held_q <= bus_rdata_i;
            S_REF_RD: save_ref_q <= bus_rdata_i;
            S_ZQ_RD:  save_zq_q  <= bus_rdata_i;
            S_ENG_POLL: if (bus_rdata_i[0]) begin
              if (poll_last) begin
                tmo_q  <= 1'b1;
                step_q <= S_WL_EXIT;
              end else begin
                step_q <= S_ENG_POLL;
              end
            end
            S_CHK0, S_CHK1: err_q <= err_q | (|bus_rdata_i[ERR_LSB +: ERR_W]);
            S_CMD_CLR: begin
              state_q <= ST_IDLE;
              step_q  <= S_PDC_RD;
              done_q  <= 1'b1;
            end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/wl_calib_seq_chk.sv
module wl_calib_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_we_o,
  input logic          bus_re_o,
  input logic [DW-1:0] bus_rdata_i,
  input logic          bus_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          timeout_o
);
  // R2
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) && !bus_ready_i |=>
      $stable(bus_we_o) && $stable(bus_re_o) && $stable(bus_addr_o) && $stable(bus_wdata_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(bus_we_o || bus_re_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(bus_we_o && bus_ready_i && (bus_wdata_o == '0)));

  // R7
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(bus_re_o && bus_ready_i));

  // R8
  tmo_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(bus_re_o && bus_ready_i && bus_rdata_i[0]));
endmodule

bind wl_calib_seq wl_calib_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_we_o   (bus_we_o),
  .bus_re_o   (bus_re_o),
  .bus_rdata_i(bus_rdata_i),
  .bus_ready_i(bus_ready_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .timeout_o  (timeout_o)
);

// File: tb/wl_calib_seq_bench.sv
`timescale 1ns/1ps
module wl_calib_seq_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LIM = 8;
  localparam logic [AW-1:0] P1 = 16'h4000;
  localparam logic [AW-1:0] A_PDC = 16'h0004, A_APS = 16'h0404, A_REF = 16'h0020;
  localparam logic [AW-1:0] A_ZQ = 16'h0800, A_CMD = 16'h001C, A_LVL = 16'h0808;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic we, re, ready, busy, done, err, tmo;

  always #2.5 clk = ~clk;

  wl_calib_seq #(.AW(AW), .DW(DW), .PHY1_BASE(P1), .POLL_MAX(LIM)) u_wl_calib_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
    .bus_rdata_i(rdata), .bus_ready_i(ready),
    .busy_o(busy), .done_o(done), .err_o(err), .timeout_o(tmo));

  // slave configuration, driven only by the main initial block
  logic [31:0] c_pdc, c_aps, c_ref, c_zq, c_st0, c_st1;
  int c_busy;
  logic load = 1'b0;

  // slave model
  logic [31:0] r_pdc, r_aps, r_ref, r_zq, r_cmd, r_lvl0, r_lvl1;
  int busy_left, wcnt, txn;
  always @(posedge clk) begin
    if (load) begin
      r_pdc <= c_pdc; r_aps <= c_aps; r_ref <= c_ref; r_zq <= c_zq;
      r_cmd <= '0; r_lvl0 <= '0; r_lvl1 <= c_st1; busy_left <= 0;
      wcnt <= 0; ready <= 1'b0; rdata <= '0;
    end else if (ready) begin
      ready <= 1'b0;
    end else if (we || re) begin
      if (wcnt >= txn % 3) begin
        ready <= 1'b1;
        wcnt  <= 0;
        txn   <= txn + 1;
        if (we) begin
          case (addr)
            A_PDC: r_pdc <= wdata;
            A_APS: r_aps <= wdata;
            A_REF: r_ref <= wdata;
            A_ZQ:  r_zq  <= wdata;
            A_CMD: r_cmd <= wdata;
            A_LVL: if (wdata[0]) begin
              if (c_busy == 0) r_lvl0 <= c_st0;
              else begin r_lvl0 <= 32'h1; busy_left <= c_busy; end
            end
            default: ;
          endcase
        end else begin
          case (addr)
            A_PDC: rdata <= r_pdc;
            A_APS: rdata <= r_aps;
            A_REF: rdata <= r_ref;
            A_ZQ:  rdata <= r_zq;
            A_CMD: rdata <= r_cmd;
            A_LVL: if (busy_left != 0) begin
              rdata <= r_lvl0 | 32'h1;
              busy_left <= busy_left - 1;
              if (busy_left == 1) r_lvl0 <= c_st0;
            end else rdata <= r_lvl0;
            P1 + A_LVL: rdata <= r_lvl1;
            default: rdata <= 32'hDEAD_BEEF;
          endcase
        end
      end else wcnt <= wcnt + 1;
    end
  end

  initial begin txn = 0; wcnt = 0; busy_left = 0; ready = 1'b0; rdata = '0; end

  // scoreboard
  typedef struct {
    bit          w;
    logic [15:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t q[$];

  int m_checks = 0, m_fails = 0, done_cnt = 0;
  int t_checks = 0, t_fails = 0;

  always @(negedge clk) begin
    if (rst_n && done) done_cnt <= done_cnt + 1;
    if (rst_n && ready && (we || re)) begin
      m_checks <= m_checks + 1;
      if (q.size() == 0) begin
        m_fails <= m_fails + 1;
        $display("FAIL R11 unexpected access we=%0b addr=%h data=%h, expected none", we, addr, wdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (we !== e.w || addr !== e.a || (e.w && wdata !== e.d)) begin
          m_fails <= m_fails + 1;
          $display("FAIL %s access actual we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                   e.tag, we, addr, wdata, e.w, e.a, e.d);
        end
      end
    end
  end

  task automatic push(input bit w, input logic [15:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.w = w; e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_expected(input int nbusy);
    logic [31:0] pdc1, aps1;
    pdc1 = c_pdc & ~32'h0000FF00;
    aps1 = c_aps | 32'h1;
    push(0, A_PDC, 0, "R3"); push(1, A_PDC, pdc1, "R3");
    push(0, A_APS, 0, "R3"); push(1, A_APS, aps1, "R3");
    push(0, A_REF, 0, "R4"); push(1, A_REF, 32'h0000C000, "R4");
    push(0, A_ZQ, 0, "R4");  push(1, A_ZQ, c_zq & ~32'h3, "R4");
    push(1, A_CMD, 32'h00808231, "R5"); push(1, A_LVL, 32'h1, "R5");
    if (nbusy >= LIM) begin
      for (int i = 0; i < LIM; i++) push(0, A_LVL, 0, "R8");
    end else begin
      for (int i = 0; i <= nbusy; i++) push(0, A_LVL, 0, "R6");
      push(0, A_LVL, 0, "R7"); push(0, P1 + A_LVL, 0, "R7");
    end
    push(1, A_CMD, 32'h00048031, "R9");
    push(1, A_REF, c_ref, "R9"); push(1, A_ZQ, c_zq, "R9");
    push(0, A_PDC, 0, "R9"); push(1, A_PDC, pdc1 | 32'h5500, "R9");
    push(0, A_APS, 0, "R9"); push(1, A_APS, aps1 & ~32'h8, "R9");
    push(1, A_CMD, 32'h0, "R9");
  endtask

  task automatic run_case(input logic [31:0] pdc, aps, rf, zq, input int nbusy,
                          input logic [31:0] st0, st1, input bit exp_err, exp_tmo,
                          input bit extra_start);
    int d0, n;
    c_pdc = pdc; c_aps = aps; c_ref = rf; c_zq = zq; c_busy = nbusy; c_st0 = st0; c_st1 = st1;
    @(negedge clk); load = 1'b1; @(negedge clk); load = 1'b0;
    build_expected(nbusy);
    d0 = done_cnt;
    start = 1'b1; @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      if (extra_start && (n % 9 == 4)) start = 1'b1; else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    chk(done === 1'b1, "R10 done seen", {31'b0, done}, 32'h1);
    chk(busy === 1'b0, "R10 busy low at done", {31'b0, busy}, 32'h0);
    chk(err === exp_err, "R7 err flag", {31'b0, err}, {31'b0, exp_err});
    chk(tmo === exp_tmo, "R8 timeout flag", {31'b0, tmo}, {31'b0, exp_tmo});
    repeat (12) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10 done width", done_cnt - d0, 1);
    chk(q.size() == 0, "R11 stream complete, no extra run", q.size(), 0);
    chk(err === exp_err && tmo === exp_tmo, "R10 flags held", {30'b0, err, tmo}, {30'b0, exp_err, exp_tmo});
    q.delete();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", t_checks + m_checks - t_fails - m_fails,
               t_checks + m_checks + 1);
      $finish;
    end
  end

  initial begin
    c_pdc = '0; c_aps = '0; c_ref = '0; c_zq = '0; c_st0 = '0; c_st1 = '0; c_busy = 0;
    repeat (3) @(negedge clk);
    load = 1'b1; @(negedge clk); load = 1'b0;
    chk(!busy && !done && !err && !tmo && !we && !re, "R1 reset state",
        {26'b0, busy, done, err, tmo, we, re}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !we && !re, "R1 idle after reset", {29'b0, busy, we, re}, 32'h0);

    run_case(32'h0000_FF37, 32'h0000_0008, 32'h0000_7800, 32'hA5A5_0003, 3, 32'h0, 32'h0, 0, 0, 0);
    run_case(32'hFFFF_FFFF, 32'h0, 32'h1, 32'h2, 0, 32'h0000_0400, 32'h0, 1, 0, 0);
    run_case(32'h1234_5678, 32'hFFFF_FFF0, 32'h0000_C001, 32'hFFFF_FFFF, 7, 32'h0000_1080, 32'h0000_0100, 1, 0, 0);
    run_case(32'h0000_AA00, 32'h5, 32'h0, 32'h0, 2, 32'h0000_10F0, 32'h0000_F0FF, 0, 0, 0);
    run_case(32'h0000_0100, 32'h0000_000F, 32'h0000_1234, 32'h0000_0001, 8, 32'h0000_0F00, 32'h0000_0F00, 0, 1, 0);
    run_case(32'h0000_5500, 32'h1, 32'h0000_4321, 32'h0000_0007, 20, 32'h0, 32'h0, 0, 1, 1);
    run_case(32'h8000_00FF, 32'h8, 32'h0000_0A0A, 32'h0000_0100, 1, 32'h0, 32'h0, 0, 0, 1);

    $display("%0d/%0d checks passed", t_checks + m_checks - t_fails - m_fails, t_checks + m_checks);
    $finish;
  end
endmodule